// File: doc/BRIEF.md
# Array Access Space and Shadow Decoder

This block sits in front of a nonvolatile memory array and decides, for each bus access, where the access goes. A control-register hit always wins. Otherwise, when shadow mode is on, the access goes to a 256-byte shadow region, and only the low address byte picks the location. Otherwise the access goes to the main array, but only if its 3-bit function code matches the configured address-space field. A rejected array access does not select the array and raises an error flag on the next cycle.

The block also holds a boot-response latch. The latch is loaded at reset from the boot configuration bit and is cleared for good by the stop bit. While it is set, array and shadow reads are marked as carrying invalid data. Register accesses are not affected.

Top module: `nvm_access_qualifier`

## Requirements
- R1: With space field 2'b00, an array access is accepted (arraySel=1) when fcIn[1:0] is 2'b01 or 2'b10, and rejected for any other code.
- R2: With space field 2'b01, an array access is accepted only when fcIn[1:0] is 2'b10.
- R3: With space field 2'b10, an array access is accepted only when fcIn is 3'b101 or 3'b110.
- R4: With space field 2'b11, an array access is accepted only when fcIn is 3'b110.
- R5: A rejected array access drives arraySel low in the same cycle. It sets accErr high for exactly the one cycle after the clock edge that follows. accErr is low after any cycle with no rejected access.
- R6: In shadow mode (shadowEn=1, no register hit), shadowSel is 1 and arraySel is 0. shadowOfs equals addrIn[7:0], and the address bits above bit 7 have no effect. The space field is not checked, so no error is raised.
- R7: shadowRsvd is 1 for a shadow access with an offset from 0x00 to 0x1F, and 0 for offsets from 0x20 to 0xFF.
- R8: An access with regHit=1 gives regSel=1, arraySel=0, shadowSel=0 and no error, whatever the shadow mode, space field and function code.
- R9: At reset, bootActive is loaded with the inverse of bootCfg. Later changes of bootCfg have no effect on it.
- R10: A clock edge with stopBit=1 clears bootActive. It stays cleared until the next reset.
- R11: While bootActive is 1, dataInvalid is 1 for array and shadow reads. It is 0 for writes and for register accesses.
- R12: During and right after reset, accErr is 0 and every select output is 0 while accValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| addrIn | input | ADDR_W (18) | Access byte address |
| fcIn | input | 3 | Function code of the access |
| regHit | input | 1 | Access targets the control registers |
| spaceCfg | input | 2 | Configured array address-space field |
| shadowEn | input | 1 | Shadow mode enable |
| bootCfg | input | 1 | Boot bit; 0 at reset enables boot response |
| stopBit | input | 1 | Stop bit; ends boot response |
| arraySel | output | 1 | Main array selected |
| regSel | output | 1 | Control registers selected |
| shadowSel | output | 1 | Shadow region selected |
| shadowOfs | output | 8 | Shadow byte offset (0 when not shadow) |
| shadowRsvd | output | 1 | Shadow offset lies in the reserved low 32 bytes |
| accErr | output | 1 | One-cycle pulse after a rejected access |
| bootActive | output | 1 | Block still answers the boot address |
| dataInvalid | output | 1 | Read data is not valid because of boot response |

## Verification
The space filter is swept over function codes in each of the four space settings. The codes chosen separate the user/supervisor bit from the data/program bits: for example, 3'b101 passes under 2'b00 but fails under 2'b01. Shadow accesses use differing upper address bits at one offset, and offsets 0x1F and 0x20, to show that the upper bits are ignored and where the reserved boundary lies. Register hits are combined with shadow mode and with an illegal function code to show that register hits take priority. Reset with each boot value, followed by bootCfg toggles and stop pulses, tells the latch's load, hold and clear apart.

// File: rtl/nvmq_pkg.sv
package nvmq_pkg;

  typedef enum logic [1:0] {
    SPACE_ANY       = 2'b00,
    SPACE_USER_PROG = 2'b01,
    SPACE_SUPV      = 2'b10,
    SPACE_SUPV_PROG = 2'b11
  } spaceSel_t;

  typedef struct packed {
    logic pickReg;
    logic pickShadow;
    logic pickArray;
    logic reject;
    logic isRead;
  } accStrobe_t;

  function automatic logic spaceAllows(input logic [1:0] space, input logic [2:0] fc);
    logic userData, userProg, supData, supProg;
    userData = (fc[1:0] == 2'b01);
    userProg = (fc[1:0] == 2'b10);
    supData  = (fc == 3'b101);
    supProg  = (fc == 3'b110);
    case (spaceSel_t'(space))
      SPACE_ANY:       return userData | userProg;
      SPACE_USER_PROG: return userProg;
      SPACE_SUPV:      return supData | supProg;
      default:         return supProg;
    endcase
  endfunction

endpackage

// File: rtl/nvmq_ctrl.sv
module nvmq_ctrl
  import nvmq_pkg::*;
(
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       regHit,
  input  logic       shadowEn,
  input  logic [1:0] spaceCfg,
  input  logic [2:0] fcIn,
  output accStrobe_t strobe
);

  logic spaceOk;

  always_comb begin
    spaceOk = spaceAllows(spaceCfg, fcIn);
    strobe  = '0;
    strobe.isRead = accValid & ~accWrite;
    if (accValid) begin
      if (regHit) begin
        strobe.pickReg = 1'b1;
      end else if (shadowEn) begin
        strobe.pickShadow = 1'b1;
      end else if (spaceOk) begin
        strobe.pickArray = 1'b1;
      end else begin
        strobe.reject = 1'b1;
      end
    end
  end

endmodule

// File: rtl/nvmq_datapath.sv
module nvmq_datapath
  import nvmq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int OFS_W      = 8,
  parameter int RSVD_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  accStrobe_t        strobe,
  input  logic              bootCfg,
  input  logic              stopBit,
  output logic              arraySel,
  output logic              regSel,
  output logic              shadowSel,
  output logic [OFS_W-1:0]  shadowOfs,
  output logic              shadowRsvd,
  output logic              accErr,
  output logic              bootActive,
  output logic              dataInvalid
);

  localparam logic [OFS_W-1:0] RSVD_LIMIT = RSVD_BYTES[OFS_W-1:0];

  logic errQ;
  logic bootQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
    end else begin
      errQ <= strobe.reject;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootQ <= ~bootCfg;
    end else if (stopBit) begin
      bootQ <= 1'b0;
    end
  end

  always_comb begin
    arraySel    = strobe.pickArray;
    regSel      = strobe.pickReg;
    shadowSel   = strobe.pickShadow;
    shadowOfs   = strobe.pickShadow ? addrIn[OFS_W-1:0] : '0;
    shadowRsvd  = strobe.pickShadow & (addrIn[OFS_W-1:0] < RSVD_LIMIT);
    accErr      = errQ;
    bootActive  = bootQ;
    dataInvalid = bootQ & strobe.isRead & (strobe.pickArray | strobe.pickShadow);
  end

endmodule

// File: rtl/nvm_access_qualifier.sv
module nvm_access_qualifier
  import nvmq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int OFS_W      = 8,
  parameter int RSVD_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        fcIn,
  input  logic              regHit,
  input  logic [1:0]        spaceCfg,
  input  logic              shadowEn,
  input  logic              bootCfg,
  input  logic              stopBit,
  output logic              arraySel,
  output logic              regSel,
  output logic              shadowSel,
  output logic [OFS_W-1:0]  shadowOfs,
  output logic              shadowRsvd,
  output logic              accErr,
  output logic              bootActive,
  output logic              dataInvalid
);

  accStrobe_t strobe;

  nvmq_ctrl ctrl_i (
    .accValid (accValid),
    .accWrite (accWrite),
    .regHit   (regHit),
    .shadowEn (shadowEn),
    .spaceCfg (spaceCfg),
    .fcIn     (fcIn),
    .strobe   (strobe)
  );

  nvmq_datapath #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .RSVD_BYTES (RSVD_BYTES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .addrIn      (addrIn),
    .strobe      (strobe),
    .bootCfg     (bootCfg),
    .stopBit     (stopBit),
    .arraySel    (arraySel),
    .regSel      (regSel),
    .shadowSel   (shadowSel),
    .shadowOfs   (shadowOfs),
    .shadowRsvd  (shadowRsvd),
    .accErr      (accErr),
    .bootActive  (bootActive),
    .dataInvalid (dataInvalid)
  );

endmodule

// File: rtl/nvmq_checker.sv
module nvmq_checker #(
  parameter int ADDR_W = 18,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic              regHit,
  input logic              shadowEn,
  input logic              stopBit,
  input logic [ADDR_W-1:0] addrIn,
  input logic              arraySel,
  input logic              regSel,
  input logic              shadowSel,
  input logic [OFS_W-1:0]  shadowOfs,
  input logic              shadowRsvd,
  input logic              accErr,
  input logic              bootActive,
  input logic              dataInvalid
);

  assert_reject_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !regHit && !shadowEn && !arraySel) |=> accErr);

  assert_reg_priority_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && regHit) |-> (regSel && !arraySel && !shadowSel && !dataInvalid));

  assert_shadow_route_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && shadowEn && !regHit) |-> (shadowSel && !arraySel && shadowOfs == addrIn[OFS_W-1:0]));

  assert_rsvd_only_shadow_R7: assert property (@(posedge clk) disable iff (!rstN)
    shadowRsvd |-> shadowSel);

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopBit |=> !bootActive);

  assert_boot_no_rearm_R10: assert property (@(posedge clk) disable iff (!rstN)
    !bootActive |=> !bootActive);

  assert_invalid_on_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataInvalid |-> (bootActive && accValid && !accWrite));

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arraySel, regSel, shadowSel}));

endmodule

bind nvm_access_qualifier nvmq_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
  .regHit(regHit), .shadowEn(shadowEn), .stopBit(stopBit), .addrIn(addrIn),
  .arraySel(arraySel), .regSel(regSel), .shadowSel(shadowSel),
  .shadowOfs(shadowOfs), .shadowRsvd(shadowRsvd), .accErr(accErr),
  .bootActive(bootActive), .dataInvalid(dataInvalid)
);

// File: tb/nvm_access_qualifier_tb.sv
`timescale 1ns/1ps
module nvm_access_qualifier_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0, regHit = 1'b0;
  logic [17:0] addrIn = '0;
  logic [2:0]  fcIn = '0;
  logic [1:0]  spaceCfg = '0;
  logic        shadowEn = 1'b0, bootCfg = 1'b1, stopBit = 1'b0;
  logic        arraySel, regSel, shadowSel, shadowRsvd, accErr, bootActive, dataInvalid;
  logic [7:0]  shadowOfs;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nvm_access_qualifier dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .addrIn(addrIn), .fcIn(fcIn), .regHit(regHit), .spaceCfg(spaceCfg),
    .shadowEn(shadowEn), .bootCfg(bootCfg), .stopBit(stopBit),
    .arraySel(arraySel), .regSel(regSel), .shadowSel(shadowSel),
    .shadowOfs(shadowOfs), .shadowRsvd(shadowRsvd), .accErr(accErr),
    .bootActive(bootActive), .dataInvalid(dataInvalid)
  );

  // {space[1:0], fc[2:0], expected accept}
  localparam logic [5:0] VEC [0:16] = '{
    {2'b00, 3'b001, 1'b1}, {2'b00, 3'b010, 1'b1}, {2'b00, 3'b101, 1'b1},
    {2'b00, 3'b000, 1'b0}, {2'b00, 3'b011, 1'b0}, {2'b00, 3'b111, 1'b0},
    {2'b01, 3'b010, 1'b1}, {2'b01, 3'b110, 1'b1}, {2'b01, 3'b001, 1'b0},
    {2'b01, 3'b101, 1'b0},
    {2'b10, 3'b101, 1'b1}, {2'b10, 3'b110, 1'b1}, {2'b10, 3'b001, 1'b0},
    {2'b10, 3'b010, 1'b0},
    {2'b11, 3'b110, 1'b1}, {2'b11, 3'b101, 1'b0}, {2'b11, 3'b010, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    accValid = 1'b0; accWrite = 1'b0; regHit = 1'b0; shadowEn = 1'b0; stopBit = 1'b0;
  endtask

  task automatic doReset(input logic bootVal);
    @(negedge clk);
    bootCfg = bootVal;
    idle();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R12: reset state
    doReset(1'b1);
    chk("R12 accErr", accErr, 0);
    chk("R12 selects", {arraySel, regSel, shadowSel}, 0);
    chk("R9 bootActive boot=1", bootActive, 0);

    // R1..R4 space filter sweep, R5 error pulse
    for (int i = 0; i < 17; i++) begin
      spaceCfg = VEC[i][5:4];
      fcIn     = VEC[i][3:1];
      addrIn   = 18'h2A5C3;
      accValid = 1'b1;
      #1;
      case (VEC[i][5:4])
        2'b00:   chk("R1 arraySel", arraySel, VEC[i][0]);
        2'b01:   chk("R2 arraySel", arraySel, VEC[i][0]);
        2'b10:   chk("R3 arraySel", arraySel, VEC[i][0]);
        default: chk("R4 arraySel", arraySel, VEC[i][0]);
      endcase
      @(negedge clk);
      chk("R5 accErr after access", accErr, !VEC[i][0]);
    end

    // R5: a single reject gives a single-cycle pulse
    spaceCfg = 2'b11; fcIn = 3'b010; accValid = 1'b1;
    @(negedge clk);
    idle();
    chk("R5 pulse high", accErr, 1);
    @(negedge clk);
    chk("R5 pulse ends", accErr, 0);

    // R6: shadow redirect, upper bits ignored, no space check
    shadowEn = 1'b1; accValid = 1'b1; spaceCfg = 2'b11; fcIn = 3'b001;
    addrIn = 18'h3FF45; #1;
    chk("R6 shadowSel", {shadowSel, arraySel}, 2'b10);
    chk("R6 offset", shadowOfs, 8'h45);
    addrIn = 18'h00145; #1;
    chk("R6 upper bits ignored", shadowOfs, 8'h45);
    @(negedge clk);
    chk("R6 no error", accErr, 0);
    // R7 reserved boundary
    addrIn = 18'h1201F; #1;
    chk("R7 0x1F reserved", shadowRsvd, 1);
    addrIn = 18'h12020; #1;
    chk("R7 0x20 general", shadowRsvd, 0);
    addrIn = 18'h120FF; #1;
    chk("R7 0xFF general", shadowRsvd, 0);

    // R8: register priority over shadow and space filter
    regHit = 1'b1; #1;
    chk("R8 reg over shadow", {regSel, shadowSel, arraySel}, 3'b100);
    shadowEn = 1'b0; fcIn = 3'b000; #1;
    chk("R8 reg ignores space", {regSel, arraySel}, 2'b10);
    @(negedge clk);
    chk("R8 no error", accErr, 0);
    idle();

    // R9..R11: boot latch
    doReset(1'b0);
    chk("R9 bootActive boot=0", bootActive, 1);
    bootCfg = 1'b1;
    @(negedge clk);
    chk("R9 bootCfg change ignored", bootActive, 1);
    spaceCfg = 2'b00; fcIn = 3'b001; accValid = 1'b1; accWrite = 1'b0; #1;
    chk("R11 array read invalid", dataInvalid, 1);
    accWrite = 1'b1; #1;
    chk("R11 array write valid", dataInvalid, 0);
    regHit = 1'b1; #1;
    chk("R11 reg write proceeds", {regSel, dataInvalid}, 2'b10);
    accWrite = 1'b0; #1;
    chk("R11 reg read not flagged", dataInvalid, 0);
    regHit = 1'b0; shadowEn = 1'b1; #1;
    chk("R11 shadow read invalid", dataInvalid, 1);
    idle();
    stopBit = 1'b1;
    @(negedge clk);
    stopBit = 1'b0;
    chk("R10 stop clears", bootActive, 0);
    bootCfg = 1'b0;
    @(negedge clk);
    chk("R10 stays cleared", bootActive, 0);
    accValid = 1'b1; fcIn = 3'b001; #1;
    chk("R11 read valid after stop", dataInvalid, 0);
    idle();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule